// File: doc/BRIEF.md
# Transaction-Synchronised Interrupt Controller

This block gathers one-cycle event pulses from the port sequencers into a sticky event register. It masks them with an 8-bit enable register and drives an active-low interrupt line toward the host. A host on the management serial bus reads and clears events through a small register interface. The interrupt line must never move while that bus is carrying a transaction. The register-level access is still applied at once, but the pin only shows the result in the idle gap after the transaction closes and before the next one opens.

The serial protocol engine sits outside the block. It supplies a `bus_busy` level while a transaction is in progress and a `xfer_done` strobe when the transaction closes. A transaction counts as open from the first busy cycle until the done strobe. As an alternative to wiring the interrupt line, the host may broadcast an alert-response query. The block answers it in the same cycle whenever its interrupt line is low.

Event bit map: bit 2 is detection and classification completed. Bit 4 is power removed after a startup fault, bit 5 is power removed after an overcurrent cutoff, and bit 6 is power removed on disconnect. Bit 7 is an internal supply fault. Bits 0, 1 and 3 are auxiliary port events.

Top module: `txn_sync_irq_ctrl`

## Requirements
- R1: After reset the event register and the mask register read 0x00, `irq_n` is 1 and `alert_ack` is 0.
- R2: A 1 on `evt_in[i]` sets event bit i at the next clock edge. The bit stays set, whatever `evt_in` does, until a clear reaches it. Address 0 returns the event register and has no side effect.
- R3: A write to address 3 clears every event bit whose data bit is 1 and leaves the other bits unchanged. Reading address 3 returns 0x00.
- R4: A read of address 1 returns the event register and clears every bit it returned.
- R5: An event pulse in the same cycle as a clear of that bit, by address 1 or address 3, leaves the bit set.
- R6: Address 2 is the read/write mask register. An interrupt is pending when the event register AND the mask register is nonzero.
- R7: While a transaction is open, `irq_n` holds its value. A transaction is open from a cycle with `bus_busy`=1 until the cycle holding `xfer_done`=1 with `bus_busy`=0, inclusive.
- R8: At each clock edge that ends a cycle with no open transaction, `irq_n` takes the inverse of the pending state in that cycle. A clear or a new event during a transaction therefore reaches the pin on the second edge after `xfer_done`, if the bus stays idle.
- R9: `alert_ack` is 1 exactly in cycles where `alert_query` is 1 and `irq_n` is 0.
- R10: With mask 0xF4, events on bits 2, 4, 5, 6 and 7 raise the interrupt and events on bits 0, 1 and 3 alone do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 8 | Event pulses from the port sequencers |
| bus_busy | input | 1 | Serial bus transaction in progress |
| xfer_done | input | 1 | Transaction-complete strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 status, 1 status with clear, 2 mask, 3 clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| alert_query | input | 1 | Alert-response query on the bus |
| alert_ack | output | 1 | Acknowledge of the alert-response query |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench clears an event inside a transaction and checks that the pin holds low until the gap after `xfer_done`. A controller that updated on the raw register state would release the line mid-transaction. It pulses an event in the same cycle as a clear-on-read and as a clear-register write; a design with the wrong priority would lose that event and never interrupt for it. It checks that `bus_busy` dropping before `xfer_done` keeps the pin frozen, and that the alert acknowledge follows the frozen pin rather than the live pending state. It also applies mask 0xF4 to every single source, so a wrong enable bit shows as a missing or spurious interrupt.

// File: rtl/txn_irq_pkg.sv
package txn_irq_pkg;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_TAKE   = 2'd1,
    RA_MASK   = 2'd2,
    RA_CLEAR  = 2'd3
  } reg_addr_e;

  localparam int EV_AUX0        = 0;
  localparam int EV_AUX1        = 1;
  localparam int EV_CLASS_DONE  = 2;
  localparam int EV_AUX3        = 3;
  localparam int EV_OFF_START   = 4;
  localparam int EV_OFF_OVERCUR = 5;
  localparam int EV_OFF_UNPLUG  = 6;
  localparam int EV_SUPPLY_FLT  = 7;

  localparam int          EVT_W_DEF    = 8;
  localparam logic [7:0]  MASK_TYPICAL = 8'hF4;

endpackage

// File: rtl/irq_evt_bank.sv
module irq_evt_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set beats clear: a fresh event is never lost to a coincident clear
  function automatic logic next_bit(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= next_bit(q[i], set_i[i], clr_i[i]);
    end
  end

  assign q_o = q;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import txn_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] clr_o,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  reg_addr_e    ra;

  assign ra = reg_addr_e'(addr_i);

  function automatic logic [W-1:0] clear_vec(
    input logic rd, input logic wr, input reg_addr_e a,
    input logic [W-1:0] wd, input logic [W-1:0] ev);
    logic [W-1:0] c;
    c = '0;
    if (wr && a == RA_CLEAR) c = c | wd;
    if (rd && a == RA_TAKE)  c = c | ev;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                    mask_q <= '0;
    else if (wr_i && ra == RA_MASK) mask_q <= wdata_i;
  end

  always_comb begin
    unique case (ra)
      RA_STATUS, RA_TAKE: rdata_o = evt_i;
      RA_MASK:            rdata_o = mask_q;
      default:            rdata_o = '0;
    endcase
  end

  assign clr_o  = clear_vec(rd_i, wr_i, ra, wdata_i, evt_i);
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_txn_gate.sv
module irq_txn_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic done_i,
  input  logic pend_i,
  output logic win_o,
  output logic irq_n_o
);
  logic in_xfer_q;
  logic irq_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      in_xfer_q <= 1'b0;
    else if (busy_i) in_xfer_q <= 1'b1;
    else if (done_i) in_xfer_q <= 1'b0;
  end

  assign win_o = !busy_i && !in_xfer_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     irq_n_q <= 1'b1;
    else if (win_o) irq_n_q <= ~pend_i;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/txn_sync_irq_ctrl.sv
module txn_sync_irq_ctrl
  import txn_irq_pkg::*;
#(
  parameter int NUM_EVT = EVT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               bus_busy,
  input  logic               xfer_done,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NUM_EVT-1:0] reg_rdata,
  input  logic               alert_query,
  output logic               alert_ack,
  output logic               irq_n
);
  logic [NUM_EVT-1:0] evt_q;
  logic [NUM_EVT-1:0] clr_vec;
  logic [NUM_EVT-1:0] mask_q;
  logic               pending;
  logic               win_open;

  function automatic logic pend_of(input logic [NUM_EVT-1:0] ev, input logic [NUM_EVT-1:0] mk);
    return |(ev & mk);
  endfunction

  irq_evt_bank #(.W(NUM_EVT)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(evt_in), .clr_i(clr_vec), .q_o(evt_q)
  );

  irq_regif #(.W(NUM_EVT)) u_regif (
    .clk(clk), .rst_n(rst_n), .rd_i(reg_rd), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .evt_i(evt_q), .rdata_o(reg_rdata), .clr_o(clr_vec),
    .mask_o(mask_q)
  );

  assign pending = pend_of(evt_q, mask_q);

  irq_txn_gate u_gate (
    .clk(clk), .rst_n(rst_n), .busy_i(bus_busy), .done_i(xfer_done),
    .pend_i(pending), .win_o(win_open), .irq_n_o(irq_n)
  );

  assign alert_ack = alert_query & ~irq_n;
endmodule

// File: rtl/txn_irq_chk.sv
module txn_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_n,
  input logic         alert_query,
  input logic         alert_ack,
  input logic [W-1:0] evt_in,
  input logic [W-1:0] evt_q,
  input logic [W-1:0] clr_vec,
  input logic         win_open,
  input logic         pending
);
  // R2: uncleared bits persist
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ($past(evt_q) & ~$past(clr_vec))) == ($past(evt_q) & ~$past(clr_vec))));

  // R3: a cleared bit with no coincident event drops
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((evt_q & $past(clr_vec) & ~$past(evt_in)) == '0));

  // R5: events win over clears
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((evt_q & $past(evt_in)) == $past(evt_in)));

  // R7: pin frozen during a transaction
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(irq_n));

  // R8: pin follows pending in the gap
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> (irq_n == !$past(pending)));

  // R9: acknowledge only with a low pin and a query
  a_r9_ack_implies: assert property (@(posedge clk) disable iff (!rst_n)
    alert_ack |-> (alert_query && !irq_n));

  a_r9_ack_given: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_query && !irq_n) |-> alert_ack);
endmodule

bind txn_sync_irq_ctrl txn_irq_chk #(.W(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .alert_query(alert_query),
  .alert_ack(alert_ack), .evt_in(evt_in), .evt_q(evt_q), .clr_vec(clr_vec),
  .win_open(win_open), .pending(pending)
);

// File: tb/tb_txn_sync_irq_ctrl.sv
module tb_txn_sync_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] evt_in;
  logic       bus_busy, xfer_done, reg_rd, reg_wr, alert_query;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       alert_ack, irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  // reference state, derived from the requirements
  logic [7:0] m_evt, m_mask;
  logic       m_irq_n, m_open;

  always #5 clk = ~clk;

  txn_sync_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_busy(bus_busy),
    .xfer_done(xfer_done), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_query(alert_query),
    .alert_ack(alert_ack), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_rdata(input logic [1:0] a, input logic [7:0] ev, input logic [7:0] mk);
    case (a)
      2'd0, 2'd1: return ev;
      2'd2:       return mk;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_clear(input logic rd, input logic wr, input logic [1:0] a,
                                          input logic [7:0] wd, input logic [7:0] ev);
    logic [7:0] c;
    c = 8'h00;
    if (wr && a == 2'd3) c = wd;
    if (rd && a == 2'd1) c = c | ev;
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, check combinational outputs mid-cycle, advance model
  task automatic cyc(input logic busy, input logic done, input logic rd, input logic wr,
                     input logic [1:0] a, input logic [7:0] wd, input logic [7:0] ev,
                     input logic q);
    logic [7:0] clr;
    bus_busy = busy; xfer_done = done; reg_rd = rd; reg_wr = wr;
    reg_addr = a; reg_wdata = wd; evt_in = ev; alert_query = q;
    #3;
    chk(m_open ? "R7 pin" : "R8 pin", {7'd0, irq_n}, {7'd0, m_irq_n});
    chk("R9 ack", {7'd0, alert_ack}, {7'd0, q & ~m_irq_n});
    if (rd) chk(a == 2'd2 ? "R6 read" : (a == 2'd1 ? "R4 read" : (a == 2'd3 ? "R3 read" : "R2 read")),
                reg_rdata, exp_rdata(a, m_evt, m_mask));
    clr = exp_clear(rd, wr, a, wd, m_evt);
    if (!busy && !m_open) m_irq_n = ~|(m_evt & m_mask);
    m_evt = (m_evt & ~clr) | ev;
    if (wr && a == 2'd2) m_mask = wd;
    if (busy) m_open = 1'b1; else if (done) m_open = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 2'd0, 8'h00, 8'h00, 0);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    cyc(1, 0, 0, 1, a, d, 8'h00, 0);
    cyc(0, 1, 0, 0, 2'd0, 8'h00, 8'h00, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    evt_in = 0; bus_busy = 0; xfer_done = 0; reg_rd = 0; reg_wr = 0;
    reg_addr = 0; reg_wdata = 0; alert_query = 0;
    m_evt = 0; m_mask = 0; m_irq_n = 1; m_open = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #3;
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    alert_query = 1; #1;
    chk("R1 alert_ack", {7'd0, alert_ack}, 8'd0);
    alert_query = 0;
    @(posedge clk); #1;
    cyc(1, 0, 1, 0, 2'd0, 8'h00, 8'h00, 0);
    cyc(1, 0, 1, 0, 2'd2, 8'h00, 8'h00, 0);
    cyc(0, 1, 0, 0, 2'd0, 8'h00, 8'h00, 0);
    idle(2);

    // R10 typical mask, each source alone
    wr_reg(2'd2, 8'hF4);
    for (int b = 0; b < 8; b++) begin
      cyc(0, 0, 0, 0, 2'd0, 8'h00, 8'h01 << b, 0);
      idle(2);
      chk("R10 irq per source", {7'd0, irq_n}, {7'd0, !(8'hF4 >> b & 8'h01)});
      cyc(1, 0, 0, 1, 2'd3, 8'hFF, 8'h00, 1);
      cyc(0, 1, 0, 0, 2'd0, 8'h00, 8'h00, 1);
      idle(2);
    end

    // R7/R8 clear inside a transaction, pin held until after done
    cyc(0, 0, 0, 0, 2'd0, 8'h00, 8'h20, 0);
    idle(2);
    cyc(1, 0, 1, 0, 2'd1, 8'h00, 8'h00, 1);   // R4 take clears
    cyc(0, 0, 0, 0, 2'd0, 8'h00, 8'h00, 1);   // busy dropped, still open
    chk("R7 held low", {7'd0, irq_n}, 8'd0);
    cyc(0, 1, 0, 0, 2'd0, 8'h00, 8'h00, 1);
    cyc(0, 0, 0, 0, 2'd0, 8'h00, 8'h00, 1);
    chk("R8 released", {7'd0, irq_n}, 8'd1);

    // R5 event coincident with clear-on-read and with clear register
    cyc(1, 0, 1, 0, 2'd1, 8'h00, 8'h04, 0);
    cyc(1, 0, 1, 0, 2'd0, 8'h00, 8'h00, 0);
    cyc(1, 0, 0, 1, 2'd3, 8'h04, 8'h04, 0);
    cyc(1, 0, 1, 0, 2'd0, 8'h00, 8'h00, 0);
    chk("R5 bit kept", m_evt, 8'h04);
    cyc(1, 0, 0, 1, 2'd3, 8'h04, 8'h00, 0);   // R3
    cyc(0, 1, 1, 0, 2'd3, 8'h00, 8'h00, 0);
    idle(2);

    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int t = 0; t < 400; t++) begin
      int len = 1 + ($urandom % 5);
      for (int k = 0; k < len; k++) begin
        logic [7:0] ev = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
        logic rd = ($urandom % 2) == 0;
        logic wr = !rd && (($urandom % 3) == 0);
        cyc(1, 0, rd, wr, 2'($urandom), 8'($urandom), ev, ($urandom % 2) == 0);
      end
      cyc(($urandom % 8) == 0, 1, 0, 0, 2'd0, 8'h00, 8'h00, 1);
      for (int k = 0; k < int'($urandom % 4); k++)
        cyc(0, 0, 0, 0, 2'd0, 8'h00, (($urandom % 5) == 0) ? 8'($urandom) : 8'h00, ($urandom % 2) == 0);
    end

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule